// File: doc/BRIEF.md
# Cascaded Display RAM Write Controller

This block takes a stream of display data bytes and stores them in a local RAM of 4-bit words. Several copies of the block can sit on the same byte stream. Each copy has a 3-bit strap address and keeps a software-loaded subaddress counter. A word is written only when that counter equals the strap value.

A word pointer advances for every word in the stream, whether or not the word is stored. When the pointer runs past the last RAM word, it wraps to zero and the subaddress counter steps up by one. Filling continues on the next device in the chain, even when the handover falls partway through a byte.

Each byte is cut into RAM words according to the drive mode. In the static and two-way modes, an input bank select can steer the stored bits into the upper half of each word. The other bits of the word are left untouched.

Top module: `dram_cascade_wr`

## Requirements
- R1: After reset the pointer and the subaddress counter read 0 and every RAM word reads 0.
- R2: A subaddress load strobe sets the counter to the supplied value on the next cycle. A pointer load strobe sets the pointer to the supplied value, or to 0 when that value is not below DEPTH. Both strobes may act in the same cycle.
- R3: A byte presented in the same cycle as either load strobe is discarded: nothing is written, and neither the pointer nor the residue is advanced by it.
- R4: Mode codes and unpacking: 0 is static (eight 1-bit words per byte), 1 is two-way (four 2-bit words), 2 is three-way (3-bit words packed across bytes), 3 is four-way (two 4-bit words). Byte bits are consumed MSB first. The first word lands at the current pointer and later words at following addresses.
- R5: For each accepted byte, the pointer advances by the number of words taken from it, whether or not any word was stored.
- R6: A word is stored only when the subaddress in force for that word equals the strap input. On a mismatch the RAM is left as it was.
- R7: Wrap is decided word by word. A word that would fall at address DEPTH goes to address 0, and it and the words after it use subaddress +1 (mod 8). After the byte, the counter holds that incremented value.
- R8: Bit placement with bank 0: static fills bit 0, two-way fills bits 1:0, three-way fills bits 2:0, four-way fills bits 3:0. The earliest stream bit of a word goes into the highest bit that is filled. Bits that are not filled keep their old value.
- R9: With the bank select at 1, static mode fills bit 2 and two-way mode fills bits 3:2. The select has no effect in three-way and four-way modes.
- R10: In three-way mode, the 1 or 2 bits left at the end of a byte are held and placed ahead of the next byte's bits. Either load strobe, or a byte accepted in another mode, clears the held bits.
- R11: The pointer is always below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Drive mode code (R4) |
| in_bank_i | input | 1 | Input bank select for static and two-way modes |
| strap_i | input | 3 | Strap device address |
| sub_load_i | input | 1 | Subaddress counter load strobe |
| sub_val_i | input | 3 | Value for the subaddress counter |
| ptr_load_i | input | 1 | Pointer load strobe |
| ptr_val_i | input | PTR_W | Value for the pointer |
| byte_valid_i | input | 1 | A data byte is offered this cycle |
| byte_i | input | 8 | Data byte |
| rd_addr_i | input | PTR_W | RAM read address |
| rd_data_o | output | 4 | RAM word at rd_addr_i (combinational) |
| ptr_o | output | PTR_W | Current pointer |
| sub_o | output | 3 | Current subaddress counter |

## Verification
The properties on RAM contents assume that the strap input and the read address do not change between the edge that accepts a byte and the following edge. The stimulus changes the strap only on idle cycles, and it finishes its read-back sweep with the read address parked at the same word. The step-size property covers only the fixed-ratio modes, so the bench holds mode and bank steady for as long as three-way residue bits are pending. It changes them only together with a load strobe, which clears that residue.

// File: rtl/dram_pkg.sv
package dram_pkg;
   localparam int SLOTS  = 8;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 4;
   localparam int SUB_W  = 3;

   typedef enum logic [1:0] {
      MODE_STATIC = 2'd0,
      MODE_DUO    = 2'd1,
      MODE_TRI    = 2'd2,
      MODE_QUAD   = 2'd3
   } drive_mode_e;

   function automatic int group_width(input drive_mode_e m);
      case (m)
         MODE_STATIC: return 1;
         MODE_DUO:    return 2;
         MODE_TRI:    return 3;
         default:     return 4;
      endcase
   endfunction
endpackage

// File: rtl/dram_unpack.sv
module dram_unpack
   import dram_pkg::*;
(
   input  drive_mode_e                     mode_i,
   input  logic                            bank_i,
   input  logic [BYTE_W-1:0]               byte_i,
   input  logic [1:0]                      res_bits_i,
   input  logic [1:0]                      res_cnt_i,
   output logic [3:0]                      cnt_o,
   output logic [SLOTS-1:0][WORD_W-1:0]    data_o,
   output logic [WORD_W-1:0]               mask_o,
   output logic [1:0]                      res_bits_o,
   output logic [1:0]                      res_cnt_o
);
   // stream = held bits above the new byte; valid length is len, MSB first
   logic [BYTE_W+1:0] stream;
   logic [BYTE_W+1:0] shifted;
   logic [WORD_W-1:0] gmask;
   int len, gw, n, left, base;

   assign stream = {res_bits_i, byte_i};

   always_comb begin
      gw      = group_width(mode_i);
      len     = BYTE_W + ((mode_i == MODE_TRI) ? int'(res_cnt_i) : 0);
      n       = len / gw;
      left    = len - n * gw;
      base    = (bank_i && (mode_i == MODE_STATIC || mode_i == MODE_DUO)) ? 2 : 0;
      gmask   = WORD_W'((1 << gw) - 1);
      mask_o  = gmask << base;
      cnt_o   = 4'(n);
      shifted = '0;
      for (int j = 0; j < SLOTS; j++) begin
         data_o[j] = '0;
         if (j < n) begin
            shifted   = stream >> (len - gw * (j + 1));
            data_o[j] = (shifted[WORD_W-1:0] & gmask) << base;
         end
      end
      if (mode_i == MODE_TRI) begin
         res_bits_o = stream[1:0] & 2'((1 << left) - 1);
         res_cnt_o  = 2'(left);
      end else begin
         res_bits_o = '0;
         res_cnt_o  = '0;
      end
   end
endmodule

// File: rtl/dram_slot_map.sv
module dram_slot_map
   import dram_pkg::*;
#(
   parameter int DEPTH = 40,
   parameter int PTR_W = 6
) (
   input  logic [PTR_W-1:0]             ptr_i,
   input  logic [SUB_W-1:0]             sub_i,
   input  logic [SUB_W-1:0]             strap_i,
   input  logic [3:0]                   cnt_i,
   output logic [SLOTS-1:0][PTR_W-1:0]  addr_o,
   output logic [SLOTS-1:0]             en_o,
   output logic [PTR_W-1:0]             nxt_ptr_o,
   output logic [SUB_W-1:0]             nxt_sub_o
);
   localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(DEPTH);

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      logic [PTR_W:0] raw;
      logic           wrap;
      assign raw       = {1'b0, ptr_i} + (PTR_W+1)'(k);
      assign wrap      = (raw >= LIMIT);
      assign addr_o[k] = wrap ? PTR_W'(raw - LIMIT) : raw[PTR_W-1:0];
      assign en_o[k]   = (4'(k) < cnt_i) && ((sub_i + SUB_W'(wrap)) == strap_i);
   end

   logic [PTR_W:0] raw_n;
   logic           wrap_n;
   assign raw_n     = {1'b0, ptr_i} + (PTR_W+1)'(cnt_i);
   assign wrap_n    = (raw_n >= LIMIT);
   assign nxt_ptr_o = wrap_n ? PTR_W'(raw_n - LIMIT) : raw_n[PTR_W-1:0];
   assign nxt_sub_o = sub_i + SUB_W'(wrap_n);
endmodule

// File: rtl/dram_store.sv
module dram_store
   import dram_pkg::*;
#(
   parameter int DEPTH = 40,
   parameter int PTR_W = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we_i,
   input  logic [SLOTS-1:0][PTR_W-1:0]     addr_i,
   input  logic [SLOTS-1:0]                en_i,
   input  logic [SLOTS-1:0][WORD_W-1:0]    data_i,
   input  logic [WORD_W-1:0]               mask_i,
   input  logic [PTR_W-1:0]                rd_addr_i,
   output logic [WORD_W-1:0]               rd_data_o
);
   logic [DEPTH-1:0][WORD_W-1:0] mem_flat;

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      logic [WORD_W-1:0] word_q, word_d;
      always_comb begin
         word_d = word_q;
         if (we_i) begin
            for (int k = 0; k < SLOTS; k++) begin
               if (en_i[k] && addr_i[k] == PTR_W'(a))
                  word_d = (word_d & ~mask_i) | (data_i[k] & mask_i);
            end
         end
      end
      always_ff @(posedge clk) begin
         if (!rst_n) word_q <= '0;
         else        word_q <= word_d;
      end
      assign mem_flat[a] = word_q;
   end

   always_comb begin
      rd_data_o = '0;
      for (int a = 0; a < DEPTH; a++)
         if (rd_addr_i == PTR_W'(a)) rd_data_o = mem_flat[a];
   end
endmodule

// File: rtl/dram_cascade_wr.sv
module dram_cascade_wr
   import dram_pkg::*;
#(
   parameter  int DEPTH = 40,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic              in_bank_i,
   input  logic [2:0]        strap_i,
   input  logic              sub_load_i,
   input  logic [2:0]        sub_val_i,
   input  logic              ptr_load_i,
   input  logic [PTR_W-1:0]  ptr_val_i,
   input  logic              byte_valid_i,
   input  logic [7:0]        byte_i,
   input  logic [PTR_W-1:0]  rd_addr_i,
   output logic [3:0]        rd_data_o,
   output logic [PTR_W-1:0]  ptr_o,
   output logic [2:0]        sub_o
);
   if (DEPTH < SLOTS) begin : g_depth_chk
      $error("dram_cascade_wr: DEPTH must hold at least one full byte of words");
   end

   logic [PTR_W-1:0]               ptr_q, nxt_ptr;
   logic [SUB_W-1:0]               sub_q, nxt_sub;
   logic [1:0]                     res_bits_q, res_cnt_q, nxt_bits, nxt_cnt;
   logic [3:0]                     cnt;
   logic [SLOTS-1:0][WORD_W-1:0]   data;
   logic [SLOTS-1:0][PTR_W-1:0]    addr;
   logic [SLOTS-1:0]               en;
   logic [WORD_W-1:0]              mask;
   logic                           any_load, accept;
   drive_mode_e                    mode;

   assign mode     = drive_mode_e'(mode_i);
   assign any_load = ptr_load_i | sub_load_i;
   assign accept   = byte_valid_i & ~any_load;

   dram_unpack i_unpack (
      .mode_i    (mode),
      .bank_i    (in_bank_i),
      .byte_i    (byte_i),
      .res_bits_i(res_bits_q),
      .res_cnt_i (res_cnt_q),
      .cnt_o     (cnt),
      .data_o    (data),
      .mask_o    (mask),
      .res_bits_o(nxt_bits),
      .res_cnt_o (nxt_cnt)
   );

   dram_slot_map #(.DEPTH(DEPTH), .PTR_W(PTR_W)) i_map (
      .ptr_i    (ptr_q),
      .sub_i    (sub_q),
      .strap_i  (strap_i),
      .cnt_i    (cnt),
      .addr_o   (addr),
      .en_o     (en),
      .nxt_ptr_o(nxt_ptr),
      .nxt_sub_o(nxt_sub)
   );

   dram_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (accept),
      .addr_i   (addr),
      .en_i     (en),
      .data_i   (data),
      .mask_i   (mask),
      .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         sub_q      <= '0;
         res_bits_q <= '0;
         res_cnt_q  <= '0;
      end else begin
         if (ptr_load_i)
            ptr_q <= ({1'b0, ptr_val_i} < (PTR_W+1)'(DEPTH)) ? ptr_val_i : '0;
         else if (accept)
            ptr_q <= nxt_ptr;
         if (sub_load_i)
            sub_q <= sub_val_i;
         else if (accept)
            sub_q <= nxt_sub;
         if (any_load) begin
            res_bits_q <= '0;
            res_cnt_q  <= '0;
         end else if (accept) begin
            res_bits_q <= nxt_bits;
            res_cnt_q  <= nxt_cnt;
         end
      end
   end

   assign ptr_o = ptr_q;
   assign sub_o = sub_q;
endmodule

// File: rtl/dram_cascade_wr_chk.sv
module dram_cascade_wr_chk #(
   parameter  int DEPTH = 40,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        mode_i,
   input logic              in_bank_i,
   input logic [2:0]        strap_i,
   input logic              sub_load_i,
   input logic [2:0]        sub_val_i,
   input logic              ptr_load_i,
   input logic [PTR_W-1:0]  ptr_val_i,
   input logic              byte_valid_i,
   input logic [7:0]        byte_i,
   input logic [PTR_W-1:0]  rd_addr_i,
   input logic [3:0]        rd_data_o,
   input logic [PTR_W-1:0]  ptr_o,
   input logic [2:0]        sub_o
);
   logic any_load, take;
   int   step;
   assign any_load = ptr_load_i | sub_load_i;
   assign take     = byte_valid_i & ~any_load;
   always_comb begin
      case (mode_i)
         2'd0:    step = 8;
         2'd1:    step = 4;
         default: step = 2;
      endcase
   end

   assert_ptr_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr_o) < DEPTH);

   assert_sub_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sub_load_i |=> sub_o == $past(sub_val_i));

   assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_load_i && int'(ptr_val_i) < DEPTH) |=> ptr_o == $past(ptr_val_i));

   assert_load_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid_i && any_load) |=> ($stable(rd_addr_i) -> $stable(rd_data_o)));

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mode_i != 2'd2 && int'(ptr_o) + step < DEPTH)
      |=> int'(ptr_o) == int'($past(ptr_o)) + $past(step));

   assert_wrap_sub_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !any_load |=> ((ptr_o < $past(ptr_o)) == (sub_o == $past(sub_o) + 3'd1)));

   assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && sub_o != strap_i && sub_o + 3'd1 != strap_i)
      |=> ($stable(rd_addr_i) -> $stable(rd_data_o)));
endmodule

bind dram_cascade_wr dram_cascade_wr_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/test_dram_cascade_wr.sv
`timescale 1ns/100ps
module test_dram_cascade_wr;
   localparam int DEPTH = 40;
   localparam int PTR_W = $clog2(DEPTH);

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] mode = '0;
   logic bank = 1'b0;
   logic [2:0] strap = 3'd5, sub_val = '0;
   logic sub_load = 1'b0, ptr_load = 1'b0, bvalid = 1'b0;
   logic [PTR_W-1:0] ptr_val = '0, rd_addr = '0;
   logic [7:0] bdata = '0;
   logic [3:0] rd_data;
   logic [PTR_W-1:0] ptr_o;
   logic [2:0] sub_o;

   int checks = 0, errors = 0;
   int mem [DEPTH];
   int mptr = 0, msub = 0, rbits = 0, rcnt = 0;

   always #5 clk = ~clk;

   dram_cascade_wr #(.DEPTH(DEPTH)) i_dram_cascade_wr (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_bank_i(bank), .strap_i(strap),
      .sub_load_i(sub_load), .sub_val_i(sub_val), .ptr_load_i(ptr_load), .ptr_val_i(ptr_val),
      .byte_valid_i(bvalid), .byte_i(bdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .ptr_o(ptr_o), .sub_o(sub_o));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic compare_all(input string req);
      check({req, " R11 pointer"}, int'(ptr_o), mptr);
      check({req, " R7 subaddress"}, int'(sub_o), msub);
      for (int a = 0; a < DEPTH; a++) begin
         rd_addr = PTR_W'(a);
         #0.1;
         check({req, " R6 word"}, int'(rd_data), mem[a]);
      end
   endtask

   // expected behaviour built from the requirement text
   task automatic model_byte(input int b);
      int gw, len, n, v, base, val, msk;
      gw   = (mode == 2'd0) ? 1 : (mode == 2'd1) ? 2 : (mode == 2'd2) ? 3 : 4;
      len  = 8 + ((mode == 2'd2) ? rcnt : 0);
      v    = (rbits << 8) | b;
      n    = len / gw;
      base = (bank && mode < 2'd2) ? 2 : 0;
      for (int j = 0; j < n; j++) begin
         val = (v >> (len - gw * (j + 1))) & ((1 << gw) - 1);
         msk = ((1 << gw) - 1) << base;
         if (msub == int'(strap))
            mem[mptr] = (mem[mptr] & ~msk & 15) | (val << base);
         mptr++;
         if (mptr == DEPTH) begin
            mptr = 0;
            msub = (msub + 1) % 8;
         end
      end
      if (mode == 2'd2) begin
         rcnt  = len - 3 * n;
         rbits = v & ((1 << rcnt) - 1);
      end else begin
         rcnt = 0; rbits = 0;
      end
   endtask

   task automatic send(input bit pl, input int pv, input bit sl, input int sv,
                       input bit bv, input int b);
      @(negedge clk);
      ptr_load = pl; ptr_val = PTR_W'(pv);
      sub_load = sl; sub_val = 3'(sv);
      bvalid = bv; bdata = 8'(b);
      if (pl) mptr = (pv < DEPTH) ? pv : 0;
      if (sl) msub = sv;
      if (pl || sl) begin rcnt = 0; rbits = 0; end
      else if (bv) model_byte(b);
      @(negedge clk);
      ptr_load = 1'b0; sub_load = 1'b0; bvalid = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) mem[a] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1 reset");

      // R4: static bank 0, matching subaddress, single byte
      mode = 2'd0; bank = 1'b0;
      send(1, 0, 1, 5, 0, 0);
      send(0, 0, 0, 0, 1, 8'hA5);
      compare_all("R4 static unpack");
      // R8: two-way and four-way placement, other bits preserved
      mode = 2'd3; send(1, 10, 0, 0, 0, 0); send(0, 0, 0, 0, 1, 8'hF7);
      mode = 2'd1; send(1, 10, 0, 0, 0, 0); send(0, 0, 0, 0, 1, 8'h1B);
      compare_all("R8 placement");
      // R9: alternate bank in static and two-way, ignored in four-way
      bank = 1'b1;
      mode = 2'd0; send(1, 10, 0, 0, 0, 0); send(0, 0, 0, 0, 1, 8'h5C);
      mode = 2'd3; send(1, 20, 0, 0, 0, 0); send(0, 0, 0, 0, 1, 8'h9E);
      compare_all("R9 bank");
      bank = 1'b0;
      // R2: out-of-range pointer load gives 0
      send(1, 45, 0, 0, 0, 0);
      compare_all("R2 ptr range");
      // R3: byte with load strobe is discarded
      mode = 2'd0;
      send(1, 12, 0, 0, 1, 8'hFF);
      compare_all("R3 ptr strobe");
      send(0, 0, 1, 5, 1, 8'h00);
      compare_all("R3 sub strobe");
      // R10: residue cleared by a load
      mode = 2'd2;
      send(0, 0, 0, 0, 1, 8'hE3);
      send(1, 30, 0, 0, 0, 0);
      send(0, 0, 0, 0, 1, 8'h96);
      compare_all("R10 residue cleared");
      // R7: subaddress rolls from 7 to 0 inside a byte
      mode = 2'd0;
      strap = 3'd0;
      send(1, 37, 1, 7, 0, 0);
      send(0, 0, 0, 0, 1, 8'hD4);
      compare_all("R7 sub rollover");
      strap = 3'd5;

      // sweep: every mode and bank, stream crossing device boundaries
      for (int m = 0; m < 4; m++) begin
         for (int bk = 0; bk < 2; bk++) begin
            mode = 2'(m); bank = 1'(bk);
            send(1, 30 + m, 1, 4, 0, 0);
            compare_all("R2 loads");
            for (int i = 0; i < 40; i++) begin
               send(0, 0, 0, 0, 1, (i * 73 + m * 11 + bk * 5 + 17) & 255);
               compare_all((m == 2) ? "R10 sweep" : "R5 sweep");
            end
         end
      end
      finish_run();
   end
endmodule